// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds two unsigned operands of `N` bits one bit position per clock. The first operand, the augend, sits in an accumulator shift register. The second operand, the addend, sits in a companion shift register. On each step, the low bits of both registers and a stored one-bit carry feed a single full adder. The sum bit enters the top of the accumulator as both registers move one place toward bit 0. After `N` steps the accumulator holds the sum, and the carry flop holds the carry out of the top bit.

A parent block loads both operands in one cycle. The load also clears the carry and arms an internal step counter. The parent then asserts the shift enable for as many cycles as it likes, with pauses allowed. Only the first `N` enabled cycles after a load take effect. After that the busy flag falls, and the shift enable is ignored until the next load. While the addend register empties, it takes new bits from a serial input at its top end. At the end of an addition it therefore holds the next addend, delivered bit 0 first.

Top module: `bitserial_adder`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises with no load, `sum_out`, `addend_out` and `carry_out` are 0 and `busy` is 0.
- R2: A clock with `load` high puts `aug_in` into `sum_out`, puts `add_in` into `addend_out` and sets `busy` to 1, whatever `shift_en` is. Load has priority over shifting.
- R3: A step is a clock with `shift_en` high, `busy` high and `load` low. On a step, `sum_out` becomes `{s, sum_out[N-1:1]}`, where `s = sum_out[0] ^ addend_out[0] ^ carry_out`.
- R4: On a step, `addend_out` becomes `{ser_in, addend_out[N-1:1]}`. After `N` steps from a load, `addend_out` equals the `ser_in` bits of those steps, with the first step's bit at bit 0.
- R5: On a step, with x = `sum_out[0]` and y = `addend_out[0]`, `carry_out` becomes 1 when x and y are both 1. It becomes 0 when both are 0. Otherwise it keeps its value.
- R6: A clock with `shift_en` low and `load` low leaves `sum_out`, `addend_out`, `carry_out` and `busy` unchanged.
- R7: After exactly `N` steps from a load, `sum_out` equals (augend + addend) mod 2^N and `carry_out` equals bit `N` of that sum, and `busy` falls on that same clock.
- R8: While `busy` is 0 and `load` is low, `shift_en` has no effect: all outputs hold.
- R9: A load clears `carry_out` to 0, even when the previous addition ended with a carry of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous clear, active low |
| load | input | 1 | Parallel load of both operands; clears the carry and arms the step counter |
| aug_in | input | N | Augend for the load |
| add_in | input | N | Addend for the load |
| shift_en | input | 1 | Shift control; enables one step per clock while busy |
| ser_in | input | 1 | Serial bit entering the top of the addend register on each step |
| sum_out | output | N | Accumulator contents; the sum once busy has fallen |
| addend_out | output | N | Addend register contents |
| carry_out | output | 1 | Carry flop; the final carry once busy has fallen |
| busy | output | 1 | High from a load until `N` steps have been made |

## Verification
The load and each step are registered, so each result appears on the clock edge that applies it. The bench drives inputs on falling edges and checks the outputs at the next falling edge, half a cycle after that rising edge. The final sum, carry and refilled addend are due on the edge of the `N`th enabled step. A monitor pops the expected item when it sees `busy` fall and compares it there. Pauses in the shift enable add one cycle each, so the expected item does not depend on a fixed cycle count.

// File: rtl/serial_adder_pkg.sv
package serial_adder_pkg;

    typedef enum logic [1:0] {
        REG_HOLD  = 2'd0,
        REG_SHIFT = 2'd1,
        REG_LOAD  = 2'd2
    } reg_op_e;

    function automatic logic fa_sum(input logic x, input logic y, input logic z);
        return x ^ y ^ z;
    endfunction

    function automatic logic jk_next(input logic j, input logic k, input logic q);
        return (j & ~q) | (~k & q);
    endfunction

endpackage

// File: rtl/shift_reg_unit.sv
module shift_reg_unit
    import serial_adder_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  reg_op_e      op,
    input  logic [W-1:0] par_in,
    input  logic         ser_in,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] data;
    } sreg_t;

    sreg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (op)
            REG_LOAD:  st_d.data = par_in;
            REG_SHIFT: st_d.data = {ser_in, st_q.data[W-1:1]};
            default:   st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.data;

    assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == REG_HOLD) |=> $stable(q));
    assert_parallel_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == REG_LOAD) |=> (q == $past(par_in)));
    assert_serial_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == REG_SHIFT) |=> (q[W-1] == $past(ser_in)));

endmodule

// File: rtl/carry_jk_cell.sv
module carry_jk_cell
    import serial_adder_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic x,
    input  logic y,
    output logic q
);

    typedef struct packed {
        logic c;
    } carry_t;

    carry_t st_d, st_q;
    logic   j_in, k_in;

    always_comb begin
        j_in = x & y;
        k_in = ~x & ~y;
        st_d = st_q;
        if (clr)     st_d.c = 1'b0;
        else if (en) st_d.c = jk_next(j_in, k_in, st_q.c);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.c;

    assert_carry_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && x && y) |=> q);
    assert_carry_kill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && !x && !y) |=> !q);
    assert_carry_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && (x != y)) |=> (q == $past(q)));
    assert_carry_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !q);

endmodule

// File: rtl/step_counter.sv
module step_counter #(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step_req,
    output logic busy,
    output logic step_ok
);

    localparam int CW = $clog2(N + 1);

    typedef struct packed {
        logic [CW-1:0] left;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        busy    = (st_q.left != '0);
        step_ok = step_req && busy && !load;
        st_d    = st_q;
        if (load)         st_d.left = CW'(N);
        else if (step_ok) st_d.left = st_q.left - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_idle_stays_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load) |=> !busy);
    assert_load_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy);
    assert_pause_keeps_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load && !step_req) |=> busy);

endmodule

// File: rtl/bitserial_adder.sv
module bitserial_adder
    import serial_adder_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] aug_in,
    input  logic [N-1:0] add_in,
    input  logic         shift_en,
    input  logic         ser_in,
    output logic [N-1:0] sum_out,
    output logic [N-1:0] addend_out,
    output logic         carry_out,
    output logic         busy
);

    logic    step;
    logic    x_bit, y_bit, s_bit;
    reg_op_e op;

    step_counter #(.N(N)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step_req (shift_en),
        .busy     (busy),
        .step_ok  (step)
    );

    always_comb begin
        x_bit = sum_out[0];
        y_bit = addend_out[0];
        s_bit = fa_sum(x_bit, y_bit, carry_out);
        if (load)      op = REG_LOAD;
        else if (step) op = REG_SHIFT;
        else           op = REG_HOLD;
    end

    shift_reg_unit #(.W(N)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .par_in (aug_in),
        .ser_in (s_bit),
        .q      (sum_out)
    );

    shift_reg_unit #(.W(N)) u_addend (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .par_in (add_in),
        .ser_in (ser_in),
        .q      (addend_out)
    );

    carry_jk_cell u_carry (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load),
        .en    (step),
        .x     (x_bit),
        .y     (y_bit),
        .q     (carry_out)
    );

    assert_sum_bit_enters_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && busy && !load) |=>
        (sum_out[N-1] == ($past(sum_out[0]) ^ $past(addend_out[0]) ^ $past(carry_out))));
    assert_ignored_when_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load) |=> ($stable(sum_out) && $stable(addend_out) && $stable(carry_out)));
    assert_load_priority_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && shift_en) |=> (sum_out == $past(aug_in) && !carry_out));

endmodule

// File: tb/test_bitserial_adder.sv
module test_bitserial_adder;

    localparam int N = 4;

    typedef struct packed {
        logic [N-1:0] sum;
        logic         carry;
        logic [N-1:0] addend;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic [N-1:0] aug_in = '0;
    logic [N-1:0] add_in = '0;
    logic         shift_en = 1'b0;
    logic         ser_in = 1'b0;
    logic [N-1:0] sum_out, addend_out;
    logic         carry_out, busy;

    int checks = 0;
    int fails  = 0;
    exp_t sb_q[$];
    logic [N-1:0] ma, mb;
    logic         mc;
    logic         busy_prev = 1'b0;

    always #2 clk = ~clk;

    bitserial_adder #(.N(N)) i_bitserial_adder (
        .clk(clk), .rst_n(rst_n), .load(load), .aug_in(aug_in), .add_in(add_in),
        .shift_en(shift_en), .ser_in(ser_in), .sum_out(sum_out),
        .addend_out(addend_out), .carry_out(carry_out), .busy(busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push_exp(input logic [N-1:0] a, input logic [N-1:0] b, input logic [N-1:0] ser);
        exp_t e;
        logic [N:0] full;
        full     = {1'b0, a} + {1'b0, b};
        e.sum    = full[N-1:0];
        e.carry  = full[N];
        e.addend = ser;
        sb_q.push_back(e);
    endtask

    // called just after a falling edge
    task automatic do_load(input logic [N-1:0] a, input logic [N-1:0] b, input logic with_shift);
        load = 1'b1; aug_in = a; add_in = b; shift_en = with_shift; ser_in = 1'b1;
        @(negedge clk);
        load = 1'b0; shift_en = 1'b0;
        ma = a; mb = b; mc = 1'b0;
        chk("R2 load sum", sum_out, a);
        chk("R2 load addend", addend_out, b);
        chk("R9 load clears carry", carry_out, 0);
        chk("R2 busy after load", busy, 1);
    endtask

    task automatic do_shifts(input int cnt, input logic [N-1:0] ser, input int gap_at);
        for (int i = 0; i < cnt; i++) begin
            logic s;
            if (i == gap_at) begin
                shift_en = 1'b0; ser_in = ~ser[i];
                @(negedge clk);
                chk("R6 pause sum", sum_out, ma);
                chk("R6 pause addend", addend_out, mb);
                chk("R6 pause carry", carry_out, mc);
                chk("R6 pause busy", busy, 1);
            end
            shift_en = 1'b1; ser_in = ser[i];
            @(negedge clk);
            s = ma[0] ^ mb[0] ^ mc;
            if (ma[0] && mb[0]) mc = 1'b1;
            else if (!ma[0] && !mb[0]) mc = 1'b0;
            ma = {s, ma[N-1:1]};
            mb = {ser[i], mb[N-1:1]};
            chk("R3 step sum", sum_out, ma);
            chk("R4 step addend", addend_out, mb);
            chk("R5 step carry", carry_out, mc);
        end
        shift_en = 1'b0;
    endtask

    task automatic check_ignored();
        logic [N-1:0] s0, b0;
        logic         c0;
        s0 = sum_out; b0 = addend_out; c0 = carry_out;
        shift_en = 1'b1; ser_in = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R8 idle sum", sum_out, s0);
            chk("R8 idle addend", addend_out, b0);
            chk("R8 idle carry", carry_out, c0);
            chk("R8 idle busy", busy, 0);
        end
        shift_en = 1'b0;
    endtask

    task automatic run_add(input logic [N-1:0] a, input logic [N-1:0] b,
                           input logic [N-1:0] ser, input int gap_at);
        push_exp(a, b, ser);
        do_load(a, b, 1'b0);
        do_shifts(N, ser, gap_at);
        @(negedge clk);
        chk("R7 busy low after N steps", busy, 0);
    endtask

    // scoreboard monitor: compares when busy falls
    always @(negedge clk) begin
        if (rst_n && busy_prev && !busy) begin
            if (sb_q.size() == 0) begin
                chk("R7 unexpected completion", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk("R7 final sum", sum_out, e.sum);
                chk("R7 final carry", carry_out, e.carry);
                chk("R4 refilled addend", addend_out, e.addend);
            end
        end
        busy_prev = busy;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset sum", sum_out, 0);
        chk("R1 reset addend", addend_out, 0);
        chk("R1 reset carry", carry_out, 0);
        chk("R1 reset busy", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release sum", sum_out, 0);
        chk("R1 after release busy", busy, 0);

        check_ignored();
        run_add(4'd3, 4'd5, 4'hA, -1);
        run_add(4'd15, 4'd15, 4'h5, 2);
        check_ignored();
        run_add(4'd15, 4'd1, 4'h0, 0);
        run_add(4'd0, 4'd0, 4'hF, -1);
        run_add(4'd8, 4'd8, 4'h3, 3);
        run_add(4'd9, 4'd6, 4'hC, 1);
        for (int a = 1; a < 16; a += 5) begin
            for (int b = 2; b < 16; b += 4) begin
                run_add(a[N-1:0], b[N-1:0], a[N-1:0] ^ b[N-1:0], -1);
            end
        end

        // R2: load in mid-addition with shift_en also high wins over the step
        push_exp(4'd11, 4'd7, 4'h6);
        do_load(4'd14, 4'd13, 1'b0);
        do_shifts(2, 4'h0, -1);
        do_load(4'd11, 4'd7, 1'b1);
        do_shifts(N, 4'h6, -1);
        @(negedge clk);
        chk("R7 busy low after preempted run", busy, 0);
        chk("R7 scoreboard drained", sb_q.size(), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule